// File: doc/BRIEF.md
# Endpoint OUT Receive Controller

This block takes the data stage of an OUT transfer aimed at one device endpoint and stores the payload in that endpoint's byte FIFO. The link layer supplies it with a decoded stream: a strobe for the token that targets this endpoint, data bytes with a valid strobe, an end-of-packet strobe, and an error flag that reports CRC, bit-stuffing or PID faults. Bytes go into the FIFO ahead of a committed write pointer. At end of packet the block either commits them, which makes them readable, or discards them.

For every packet the block chooses one outcome: committed, errored, or refused. It records that outcome in sticky status bits, which can be merged into one interrupt line through per-bit enables. Bulk and interrupt endpoints also get a handshake request: ACK or NAK. Isochronous endpoints never get one. A force-NAK flag refuses packets. The block sets this flag by itself after a short packet unless software has disabled that behaviour. The read side is only a pop strobe with the head byte.

Top module: `usb_out_ep_rx`

## Requirements
- R1: Bytes of a clean packet, meaning no error and a length of at most `cfg_max_pkt`, become readable in arrival order only after the edge that samples `rx_eop`. At that edge status bit 0 (packet accepted) is set.
- R2: For a clean packet with `cfg_iso`=0, `hs_ack` pulses for one cycle, in the cycle after the `rx_eop` cycle. With `cfg_iso`=1, neither `hs_ack` nor `hs_nak` ever pulses.
- R3: A clean packet shorter than `cfg_max_pkt`, including a packet of zero length, also sets status bit 1 (short packet). A clean packet of exactly `cfg_max_pkt` bytes does not set it.
- R4: A clean short packet sets `force_nak` when `cfg_no_auto_nak`=0. When `cfg_no_auto_nak`=1, `force_nak` is left as it was.
- R5: If `rx_err` is seen at any point from the first byte through the `rx_eop` cycle, none of the packet's bytes become readable. Status bit 2 (packet error) is set and no handshake is issued.
- R6: A packet with more than `cfg_max_pkt` bytes is handled exactly like R5.
- R7: If the FIFO free space (capacity minus unread committed bytes) is below `cfg_max_pkt` on the token cycle, the packet is discarded. Status bit 3 (packet refused) is set at `rx_eop`, and `hs_nak` pulses in the next cycle when `cfg_iso`=0.
- R8: While `force_nak` is 1 on the token cycle, the packet is refused as in R7. Writing 1 to `fnak_clr` clears `force_nak`.
- R9: Status bits stay set until a 1 is written to the matching bit of `stat_clr`. A set and a clear in the same cycle leave the bit set.
- R10: `irq` is high exactly when some bit of `stat` is set and the matching bit of `int_en` is set.
- R11: After reset the FIFO is empty, `stat` and `force_nak` are 0, and no handshake is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_iso | input | 1 | 1: isochronous endpoint, with no handshake |
| cfg_max_pkt | input | MPS_W | Maximum packet size in bytes |
| cfg_no_auto_nak | input | 1 | 1: a short packet does not set force-NAK |
| tok_start | input | 1 | OUT token for this endpoint (one-cycle strobe) |
| rx_valid | input | 1 | `rx_data` holds a payload byte |
| rx_data | input | 8 | Payload byte |
| rx_eop | input | 1 | End of packet (never in the same cycle as `rx_valid`) |
| rx_err | input | 1 | CRC, stuffing or PID error in the current packet |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte of the committed data |
| rd_empty | output | 1 | No committed byte is unread |
| hs_ack | output | 1 | Request to send ACK |
| hs_nak | output | 1 | Request to send NAK |
| stat | output | 4 | Sticky status: 0 accepted, 1 short, 2 error, 3 refused |
| stat_clr | input | 4 | Write-1-to-clear for `stat` |
| int_en | input | 4 | Per-bit interrupt enable |
| irq | output | 1 | Combined interrupt |
| force_nak | output | 1 | Force-NAK flag |
| fnak_clr | input | 1 | Write-1-to-clear for `force_nak` |

## Verification
Full-length, short and zero-length bulk packets show whether the short-packet bit and the automatic force-NAK are tied to the byte count and to the disable control. Packets with an error in the middle, with an error on the end-of-packet cycle, and with one byte too many show whether rollback erases every speculative byte so that the next clean packet still reads back in order. Isochronous packets sent until the FIFO is full separate the free-space refusal from the force-NAK refusal and confirm that no handshake appears for either. A clear written on the same cycle as a new set, together with changes to the enables, shows whether the sticky status and the interrupt combine in the right order.

// File: rtl/usb_out_pkg.sv
package usb_out_pkg;
   typedef enum logic [1:0] {RX_IDLE, RX_RECV, RX_DROP} rx_state_e;

   localparam int ST_ACK   = 0;
   localparam int ST_SHORT = 1;
   localparam int ST_ERR   = 2;
   localparam int ST_NAK   = 3;
   localparam int ST_N     = 4;

   typedef struct packed {
      logic done_ok;
      logic short_pkt;
      logic bad_pkt;
      logic refused;
      logic auto_fnak;
   } rx_outcome_t;
endpackage

// File: rtl/ep_fifo_mem.sv
module ep_fifo_mem #(
   parameter int DEPTH = 64,
   parameter int PTR_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             commit,
   input  logic             rollback,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             rd_empty,
   output logic [PTR_W-1:0] free_cnt
);
   localparam int AW = PTR_W - 1;

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] spec_ptr, com_ptr, rd_ptr;

   assign rd_empty = (com_ptr == rd_ptr);
   assign rd_data  = mem[rd_ptr[AW-1:0]];
   assign free_cnt = PTR_W'(DEPTH) - (com_ptr - rd_ptr);

   always_ff @(posedge clk) begin
      if (wr_en) mem[spec_ptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spec_ptr <= '0;
         com_ptr  <= '0;
         rd_ptr   <= '0;
      end else begin
         if (rollback)   spec_ptr <= com_ptr;
         else if (wr_en) spec_ptr <= spec_ptr + 1'b1;
         if (commit)     com_ptr  <= spec_ptr;
         if (rd_en && !rd_empty) rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/ep_rx_ctrl.sv
module ep_rx_ctrl
   import usb_out_pkg::*;
#(
   parameter int MPS_W = 7,
   parameter int PTR_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_iso,
   input  logic [MPS_W-1:0] cfg_max_pkt,
   input  logic             cfg_no_auto_nak,
   input  logic             force_nak,
   input  logic [PTR_W-1:0] free_cnt,
   input  logic             tok_start,
   input  logic             rx_valid,
   input  logic             rx_eop,
   input  logic             rx_err,
   output logic             wr_en,
   output logic             commit,
   output logic             rollback,
   output rx_outcome_t      outcome,
   output logic             hs_ack,
   output logic             hs_nak
);
   localparam int CW = (PTR_W > MPS_W) ? PTR_W : MPS_W;

   rx_state_e        state;
   logic [MPS_W-1:0] cnt;
   logic             err_q, ovf_q;
   logic             room_ok, below_max, eop_recv, bad;

   assign room_ok   = CW'(free_cnt) >= CW'(cfg_max_pkt);
   assign below_max = cnt < cfg_max_pkt;
   assign wr_en     = (state == RX_RECV) && rx_valid && below_max;
   assign eop_recv  = (state == RX_RECV) && rx_eop;
   assign bad       = err_q || ovf_q || rx_err;
   assign commit    = eop_recv && !bad;
   assign rollback  = eop_recv && bad;

   always_comb begin
      outcome           = '0;
      outcome.done_ok   = commit;
      outcome.short_pkt = commit && below_max;
      outcome.auto_fnak = commit && below_max && !cfg_no_auto_nak;
      outcome.bad_pkt   = rollback;
      outcome.refused   = (state == RX_DROP) && rx_eop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= RX_IDLE;
         cnt    <= '0;
         err_q  <= 1'b0;
         ovf_q  <= 1'b0;
         hs_ack <= 1'b0;
         hs_nak <= 1'b0;
      end else begin
         hs_ack <= commit && !cfg_iso;
         hs_nak <= outcome.refused && !cfg_iso;
         unique case (state)
            RX_IDLE: if (tok_start) begin
               cnt   <= '0;
               err_q <= 1'b0;
               ovf_q <= 1'b0;
               state <= (!force_nak && room_ok) ? RX_RECV : RX_DROP;
            end
            RX_RECV: begin
               if (wr_en)                  cnt   <= cnt + 1'b1;
               if (rx_valid && !below_max) ovf_q <= 1'b1;
               if (rx_err)                 err_q <= 1'b1;
               if (rx_eop)                 state <= RX_IDLE;
            end
            RX_DROP: if (rx_eop) state <= RX_IDLE;
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ep_rx_status.sv
module ep_rx_status #(
   parameter int N       = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   input  logic         fnak_set,
   input  logic         fnak_clr,
   output logic [N-1:0] stat,
   output logic         force_nak,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= set[i] | (stat[i] & ~clr[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) force_nak <= 1'b0;
      else        force_nak <= fnak_set | (force_nak & ~fnak_clr);
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |(stat & en);
      end
   end else begin : g_irq_comb
      assign irq = |(stat & en);
   end
endmodule

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx
   import usb_out_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int MAX_PKT = 64,
   parameter bit IRQ_REG = 1'b0,
   localparam int PTR_W  = $clog2(DEPTH) + 1,
   localparam int MPS_W  = $clog2(MAX_PKT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_iso,
   input  logic [MPS_W-1:0] cfg_max_pkt,
   input  logic             cfg_no_auto_nak,
   input  logic             tok_start,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_eop,
   input  logic             rx_err,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             rd_empty,
   output logic             hs_ack,
   output logic             hs_nak,
   output logic [ST_N-1:0]  stat,
   input  logic [ST_N-1:0]  stat_clr,
   input  logic [ST_N-1:0]  int_en,
   output logic             irq,
   output logic             force_nak,
   input  logic             fnak_clr
);
   if (DEPTH < MAX_PKT) begin : g_bad_depth
      $error("DEPTH must hold at least MAX_PKT bytes");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("DEPTH must be a power of two");
   end

   logic             wr_en, commit, rollback;
   logic [PTR_W-1:0] free_cnt;
   rx_outcome_t      outcome;
   logic [ST_N-1:0]  st_set;

   always_comb begin
      st_set           = '0;
      st_set[ST_ACK]   = outcome.done_ok;
      st_set[ST_SHORT] = outcome.short_pkt;
      st_set[ST_ERR]   = outcome.bad_pkt;
      st_set[ST_NAK]   = outcome.refused;
   end

   ep_fifo_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(rx_data),
      .commit(commit), .rollback(rollback), .rd_en(rd_en),
      .rd_data(rd_data), .rd_empty(rd_empty), .free_cnt(free_cnt)
   );

   ep_rx_ctrl #(.MPS_W(MPS_W), .PTR_W(PTR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cfg_max_pkt(cfg_max_pkt),
      .cfg_no_auto_nak(cfg_no_auto_nak), .force_nak(force_nak),
      .free_cnt(free_cnt), .tok_start(tok_start), .rx_valid(rx_valid),
      .rx_eop(rx_eop), .rx_err(rx_err), .wr_en(wr_en), .commit(commit),
      .rollback(rollback), .outcome(outcome), .hs_ack(hs_ack), .hs_nak(hs_nak)
   );

   ep_rx_status #(.N(ST_N), .IRQ_REG(IRQ_REG)) u_stat (
      .clk(clk), .rst_n(rst_n), .set(st_set), .clr(stat_clr), .en(int_en),
      .fnak_set(outcome.auto_fnak), .fnak_clr(fnak_clr),
      .stat(stat), .force_nak(force_nak), .irq(irq)
   );
endmodule

// File: rtl/usb_out_ep_rx_chk.sv
module usb_out_ep_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_eop,
   input logic       cfg_no_auto_nak,
   input logic       hs_ack,
   input logic       hs_nak,
   input logic       rd_empty,
   input logic       force_nak,
   input logic [3:0] stat
);
   // R2: only one handshake request at a time
   p_hs_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_ack && hs_nak));

   // R2: ACK request follows an end-of-packet cycle
   p_ack_after_eop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |-> $past(rx_eop));

   // R1: committed data only appears at end of packet
   p_commit_at_eop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_empty) |-> $past(rx_eop));

   // R4: automatic force-NAK only at end of packet with auto mode on
   p_fnak_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(force_nak) |-> ($past(rx_eop) && !$past(cfg_no_auto_nak)));

   // R5: error status only rises at end of packet
   p_err_at_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[2]) |-> $past(rx_eop));

   // R7: a NAK request comes with the refused status
   p_nak_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hs_nak |-> stat[3]);
endmodule

bind usb_out_ep_rx usb_out_ep_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_eop(rx_eop), .cfg_no_auto_nak(cfg_no_auto_nak),
   .hs_ack(hs_ack), .hs_nak(hs_nak), .rd_empty(rd_empty),
   .force_nak(force_nak), .stat(stat)
);

// File: tb/usb_out_ep_rx_tb.sv
module usb_out_ep_rx_tb;
   localparam int DEPTH = 64;
   localparam int MAXP  = 64;
   localparam int MW    = $clog2(MAXP + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_iso = 1'b0, cfg_no_auto_nak = 1'b0;
   logic [MW-1:0] cfg_max_pkt = MW'(8);
   logic tok_start = 0, rx_valid = 0, rx_eop = 0, rx_err = 0, rd_en = 0, fnak_clr = 0;
   logic [7:0] rx_data = 0;
   logic [3:0] stat_clr = 0, int_en = 4'hF;
   logic [7:0] rd_data;
   logic rd_empty, hs_ack, hs_nak, irq, force_nak;
   logic [3:0] stat;

   usb_out_ep_rx #(.DEPTH(DEPTH), .MAX_PKT(MAXP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cfg_max_pkt(cfg_max_pkt),
      .cfg_no_auto_nak(cfg_no_auto_nak), .tok_start(tok_start), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_eop(rx_eop), .rx_err(rx_err), .rd_en(rd_en),
      .rd_data(rd_data), .rd_empty(rd_empty), .hs_ack(hs_ack), .hs_nak(hs_nak),
      .stat(stat), .stat_clr(stat_clr), .int_en(int_en), .irq(irq),
      .force_nak(force_nak), .fnak_clr(fnak_clr)
   );

   always #5 clk = ~clk;

   int vectors = 0, miscompares = 0, cycles = 0;
   bit started = 0;
   string phase = "R11 reset";
   logic [7:0] seed = 8'h11;

   // reference model
   logic [7:0] m_q[$], m_pend[$];
   int  m_st = 0, m_cnt = 0;
   bit  m_bad = 0, m_fnak = 0, m_ack = 0, m_nak = 0;
   logic [3:0] m_stat = 0;

   always @(posedge clk) begin
      int  free;
      logic [3:0] set;
      bit  fset;
      started = 1;
      if (!rst_n) begin
         m_q.delete(); m_pend.delete();
         m_st = 0; m_cnt = 0; m_bad = 0; m_fnak = 0; m_ack = 0; m_nak = 0; m_stat = 0;
      end else begin
         free = DEPTH - m_q.size();
         set = 0; fset = 0; m_ack = 0; m_nak = 0;
         if (rd_en && m_q.size() > 0) void'(m_q.pop_front());
         case (m_st)
            0: if (tok_start) begin
               m_cnt = 0; m_bad = 0; m_pend.delete();
               m_st = (!m_fnak && free >= int'(cfg_max_pkt)) ? 1 : 2;
            end
            1: begin
               if (rx_valid) begin
                  if (m_cnt < int'(cfg_max_pkt)) begin m_pend.push_back(rx_data); m_cnt++; end
                  else m_bad = 1;
               end
               if (rx_err) m_bad = 1;
               if (rx_eop) begin
                  if (m_bad) set[2] = 1;
                  else begin
                     foreach (m_pend[i]) m_q.push_back(m_pend[i]);
                     set[0] = 1;
                     if (m_cnt < int'(cfg_max_pkt)) begin
                        set[1] = 1;
                        if (!cfg_no_auto_nak) fset = 1;
                     end
                     m_ack = !cfg_iso;
                  end
                  m_pend.delete();
                  m_st = 0;
               end
            end
            default: if (rx_eop) begin set[3] = 1; m_nak = !cfg_iso; m_st = 0; end
         endcase
         m_stat = set | (m_stat & ~stat_clr);
         m_fnak = fset | (m_fnak & ~fnak_clr);
      end
   end

   always @(negedge clk) begin
      if (started) begin
         vectors++;
         if (rd_empty !== (m_q.size() == 0)) begin
            miscompares++;
            $display("FAIL R1 [%s] rd_empty actual=%0b expected=%0b", phase, rd_empty, m_q.size() == 0);
         end else if (m_q.size() > 0 && rd_data !== m_q[0]) begin
            miscompares++;
            $display("FAIL R1 [%s] rd_data actual=%02h expected=%02h", phase, rd_data, m_q[0]);
         end
         if (stat !== m_stat) begin
            miscompares++;
            $display("FAIL R9 [%s] stat actual=%b expected=%b", phase, stat, m_stat);
         end
         if (force_nak !== m_fnak) begin
            miscompares++;
            $display("FAIL R4 [%s] force_nak actual=%0b expected=%0b", phase, force_nak, m_fnak);
         end
         if (hs_ack !== m_ack) begin
            miscompares++;
            $display("FAIL R2 [%s] hs_ack actual=%0b expected=%0b", phase, hs_ack, m_ack);
         end
         if (hs_nak !== m_nak) begin
            miscompares++;
            $display("FAIL R7 [%s] hs_nak actual=%0b expected=%0b", phase, hs_nak, m_nak);
         end
         if (irq !== |(m_stat & int_en)) begin
            miscompares++;
            $display("FAIL R10 [%s] irq actual=%0b expected=%0b", phase, irq, |(m_stat & int_en));
         end
      end
   end

   task automatic step();
      @(negedge clk); #1;
      tok_start = 0; rx_valid = 0; rx_eop = 0; rx_err = 0; rd_en = 0;
      fnak_clr = 0; stat_clr = 0;
   endtask

   // err_at: byte index carrying rx_err, n = on the eop cycle, -1 = none
   task automatic send_pkt(input int n, input int err_at = -1, input logic [3:0] clr_at_eop = 0);
      tok_start = 1; step();
      for (int i = 0; i < n; i++) begin
         seed = seed * 8'd5 + 8'd3;
         rx_valid = 1; rx_data = seed; rx_err = (i == err_at);
         step();
      end
      rx_eop = 1; rx_err = (err_at == n); stat_clr = clr_at_eop; step();
      step(); step();
   endtask

   task automatic drain();
      for (int i = 0; i < DEPTH + 2; i++) begin rd_en = 1; step(); end
   endtask

   task automatic clear_all();
      stat_clr = 4'hF; fnak_clr = 1; step();
   endtask

   initial begin
      step(); step(); step();
      phase = "R11 reset"; step();
      rst_n = 1; step(); step();

      phase = "R1 R2 bulk full packet";       send_pkt(8);
      phase = "R1 read back";                 drain();
      phase = "R9 sticky then clear";         step(); clear_all(); step();
      phase = "R3 R4 bulk short auto nak";    send_pkt(3);
      phase = "R8 force nak refuses bulk";    send_pkt(5);
      phase = "R1 force nak data not kept";   drain();
      phase = "R8 clear force nak";           clear_all(); send_pkt(8); drain();
      cfg_no_auto_nak = 1;
      phase = "R4 short with auto nak off";   send_pkt(2);
      phase = "R3 zero length packet";        send_pkt(0);
      cfg_no_auto_nak = 0; drain(); clear_all();
      phase = "R5 error mid packet";          send_pkt(6, 2);
      phase = "R5 error on eop cycle";        send_pkt(4, 4);
      phase = "R6 packet over max size";      send_pkt(9);
      phase = "R1 clean after rollback";      send_pkt(8); drain(); clear_all();
      phase = "R9 set wins over clear";       send_pkt(8, -1, 4'h1); step();
      phase = "R10 enable masks";
      int_en = 4'h0; step(); int_en = 4'h2; step(); int_en = 4'h1; step(); int_en = 4'hF;
      drain(); clear_all();

      cfg_iso = 1;
      phase = "R2 iso clean packet";          send_pkt(8);
      phase = "R7 iso fill fifo";
      for (int k = 0; k < 7; k++) send_pkt(8);
      phase = "R7 iso no room";               send_pkt(8);
      phase = "R7 iso read partial";          rd_en = 1; step(); send_pkt(8);
      drain(); cfg_iso = 0; clear_all();
      phase = "R7 bulk no room";
      for (int k = 0; k < 8; k++) send_pkt(8);
      clear_all(); send_pkt(4);
      phase = "R3 short after drain";         drain(); send_pkt(5); drain();
      phase = "R11 reset again";              rst_n = 0; step(); step(); rst_n = 1; step(); step();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            miscompares++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
         end
      end
   end
endmodule